// File: doc/BRIEF.md
# Strobed Bus Slave with Selectable Acknowledge Timing

This block is the slave end of a parallel, strobe-controlled transfer bus. A master puts an address and a read/write level on the bus and pulls an active-low address strobe. The slave captures both as the strobe falls and checks whether the address falls in its window. A selected slave then waits for the active-low data strobe. On a write it samples the bus data a set number of cycles later. On a read it drives the data bus with the word returned by its local memory. Every cycle ends when the master releases the data strobe.

The active-low acknowledge can be placed at three points, chosen by a configuration input:
- a set number of cycles after the address is captured, before any data strobe;
- a set number of cycles after the data strobe falls, with no wait for the memory;
- only once read data is on the bus or write data has been accepted.

The two early points let the slave be tuned to how long a given master needs to sample or remove data. Both strobes pass through a synchronizer and an edge detector in the slave clock domain before any logic uses them.

The local memory side is a stream. A request channel carries valid/ready with write enable, address and write data. A response channel carries valid with read data. Back-pressure: once request valid is raised, it and its payload stay unchanged until the cycle in which ready is seen high. The response channel has no back-pressure. The slave takes a response in the cycle its valid is high, and the memory raises it for one cycle per read request.

Top module: `bus_ack_slave`

## Requirements
- R1: Address and the read/write level (1 = read, 0 = write) are captured from the bus as the address strobe falls. Changes on those lines later in the cycle do not alter the address or direction used for the memory request.
- R2: A cycle is selected when the upper SEL_BITS address bits equal SEL_VALUE (default 4'hA over address bits 7:4). An unselected cycle never lowers the acknowledge, never drives the data bus and never issues a memory request, whatever the data strobe does.
- R3: On a write, the bus data is sampled at the clock edge 3 + cfg_wr_setup edges after the first edge that sees the data strobe low. That edge is counted as edge 0. The sampled word is written to the latched address.
- R4: On a read, a memory read is issued for the latched address once the data strobe falls. The data bus is driven (bus_data_oe high) from then until the data strobe is released. It carries the memory's read word.
- R5: Mode code 2'd1 (pre-strobe): the acknowledge goes low at edge 3 + cfg_early_dly, counted from the first edge that sees the address strobe low as edge 0, even when no data strobe has arrived.
- R6: Mode code 2'd2 (post-strobe): the acknowledge goes low at edge 3 + cfg_early_dly, counted from the first edge that sees the data strobe low, regardless of memory progress.
- R7: Mode codes 2'd3 and 2'd0 (complete): on a read the acknowledge goes low only together with valid read data on the bus. On a write it goes low only after the memory has accepted the request.
- R8: The acknowledge returns high and the data bus is released at edge 2, counted from the first edge that sees the data strobe high.
- R9: In both early modes, read data that the memory returns after the acknowledge is still placed on the bus. It is held until the data strobe is released.
- R10: A memory request keeps valid, address, write enable and write data stable until it is accepted, and each selected cycle makes exactly one request.
- R11: After reset the acknowledge is high, the data bus is not driven and no memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_as_n | input | 1 | Address strobe, active low, asynchronous |
| bus_ds_n | input | 1 | Data strobe, active low, asynchronous |
| bus_rd | input | 1 | Direction: 1 read, 0 write |
| bus_addr | input | AW | Bus address |
| bus_data_in | input | DW | Bus data as seen by the slave |
| bus_data_out | output | DW | Read data driven toward the bus |
| bus_data_oe | output | 1 | Output enable for bus_data_out |
| bus_ack_n | output | 1 | Acknowledge, active low |
| cfg_ack_mode | input | 2 | Acknowledge mode code |
| cfg_early_dly | input | CW | Cycle offset for the early modes |
| cfg_wr_setup | input | CW | Write-data sampling delay |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request ready |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Request write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | DW | Read response data |

## Verification
If the sequencer held a wrong state, the acknowledge would fall at the wrong edge. That shows up within a few cycles of a strobe edge, because the bench counts edges exactly in both early modes. A wrong latched address or direction shows up at the memory port on the very next request. It also shows up later as a wrong word in the model memory or on the data bus. A stuck acknowledge or output enable shows up two edges after the data strobe is released. A sampling point one edge early or late shows up as the complement of the intended word stored in memory.

// File: rtl/bas_pkg.sv
package bas_pkg;

  typedef enum logic [1:0] {
    ACK_ZERO = 2'd0,
    ACK_PRE  = 2'd1,
    ACK_POST = 2'd2,
    ACK_DONE = 2'd3
  } ack_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETUP,
    ST_REQ,
    ST_RSP,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/bas_strobe_sync.sv
module bas_strobe_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] fall,
  output logic [N-1:0] rise
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic [STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[STAGES-1:0], raw_n[i]};
    end
    assign fall[i] =  sh[STAGES] & ~sh[STAGES-1];
    assign rise[i] = ~sh[STAGES] &  sh[STAGES-1];
  end

endmodule

// File: rtl/bas_delay_line.sv
module bas_delay_line #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg[k] <= '0;
      else if (k == 0) stg[k] <= din;
      else             stg[k] <= stg[k-1];
    end
  end

  assign dout = stg[DEPTH-1];

endmodule

// File: rtl/bas_ack_timer.sv
module bas_ack_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clear,
  input  logic [CW-1:0] dly,
  output logic          done
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (clear) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (run && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt >= dly);

endmodule

// File: rtl/bas_seq.sv
module bas_seq
  import bas_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_fall,
  input  logic          ds_fall,
  input  logic          ds_rise,
  input  logic          hit,
  input  logic [AW-1:0] addr_d,
  input  logic          rd_d,
  input  logic [DW-1:0] bus_data_in,
  input  logic [1:0]    cfg_ack_mode,
  input  logic [CW-1:0] cfg_wr_setup,
  input  logic          timer_done,
  output logic          timer_start,
  output logic          timer_clear,
  output logic          ack_n,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);

  seq_state_e    st;
  ack_mode_e     md;
  logic [AW-1:0] addr_q;
  logic          rd_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          oe_q;
  logic          ack_q;
  logic          ds_up;
  logic          data_ok;
  logic [CW-1:0] cnt;
  logic          ack_set;
  logic          early;

  assign md    = ack_mode_e'(cfg_ack_mode);
  assign early = (md == ACK_PRE) || (md == ACK_POST);

  always_comb begin
    timer_start = 1'b0;
    if (md == ACK_PRE)  timer_start = (st == ST_IDLE) && as_fall && hit;
    if (md == ACK_POST) timer_start = (st == ST_ADDR) && ds_fall;
    timer_clear = ds_rise || ((st == ST_IDLE) && !timer_start);
  end

  always_comb begin
    if (early)     ack_set = timer_done;
    else if (rd_q) ack_set = (st == ST_RSP) && mem_rsp_valid;
    else           ack_set = (st == ST_REQ) && mem_req_ready;
    ack_set = ack_set && (st != ST_IDLE) && !ds_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      oe_q    <= 1'b0;
      ack_q   <= 1'b1;
      ds_up   <= 1'b0;
      data_ok <= 1'b0;
      cnt     <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (as_fall && hit) begin
            addr_q  <= addr_d;
            rd_q    <= rd_d;
            ds_up   <= 1'b0;
            data_ok <= 1'b0;
            st      <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          if (ds_fall) begin
            cnt  <= '0;
            oe_q <= rd_q;
            st   <= rd_q ? ST_REQ : ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (cnt == cfg_wr_setup) begin
            wdata_q <= bus_data_in;
            st      <= ST_REQ;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            st <= rd_q ? ST_RSP : ST_HOLD;
            if (!rd_q) data_ok <= 1'b1;
          end
        end
        ST_RSP: begin
          if (mem_rsp_valid) begin
            rdata_q <= mem_rsp_rdata;
            data_ok <= 1'b1;
            st      <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (ds_up || ds_rise) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase

      if (ds_rise) begin
        ack_q <= 1'b1;
        oe_q  <= 1'b0;
        ds_up <= 1'b1;
      end else if (ack_set) begin
        ack_q <= 1'b0;
      end
    end
  end

  assign ack_n         = ack_q;
  assign data_out      = rdata_q;
  assign data_oe       = oe_q;
  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_we    = !rd_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = wdata_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rise |=> ack_n && !data_oe);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> ack_n && !mem_req_valid);

  // R4
  oe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> rd_q);

  // R7
  done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) && !early |-> data_ok);

  // R6
  post_after_ds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) && (md == ACK_POST) |-> (st != ST_ADDR));

endmodule

// File: rtl/bus_ack_slave.sv
module bus_ack_slave #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int CW          = 4,
  parameter int SEL_BITS    = 4,
  parameter int SEL_VALUE   = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_as_n,
  input  logic          bus_ds_n,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data_in,
  output logic [DW-1:0] bus_data_out,
  output logic          bus_data_oe,
  output logic          bus_ack_n,
  input  logic [1:0]    cfg_ack_mode,
  input  logic [CW-1:0] cfg_early_dly,
  input  logic [CW-1:0] cfg_wr_setup,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_rdata
);

  localparam int SIDE_W = AW + 1;
  localparam logic [SEL_BITS-1:0] SEL_KEY = SEL_BITS'(SEL_VALUE);

  logic [1:0]        fall;
  logic [1:0]        rise;
  logic [SIDE_W-1:0] side_d;
  logic              hit;
  logic              t_start;
  logic              t_clear;
  logic              t_done;

  bas_strobe_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw_n ({bus_ds_n, bus_as_n}),
    .fall  (fall),
    .rise  (rise)
  );

  bas_delay_line #(.W(SIDE_W), .DEPTH(SYNC_STAGES)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({bus_rd, bus_addr}),
    .dout  (side_d)
  );

  assign hit = (side_d[AW-1 -: SEL_BITS] == SEL_KEY);

  bas_ack_timer #(.CW(CW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (t_start),
    .clear (t_clear),
    .dly   (cfg_early_dly),
    .done  (t_done)
  );

  bas_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .as_fall       (fall[0]),
    .ds_fall       (fall[1]),
    .ds_rise       (rise[1]),
    .hit           (hit),
    .addr_d        (side_d[AW-1:0]),
    .rd_d          (side_d[AW]),
    .bus_data_in   (bus_data_in),
    .cfg_ack_mode  (cfg_ack_mode),
    .cfg_wr_setup  (cfg_wr_setup),
    .timer_done    (t_done),
    .timer_start   (t_start),
    .timer_clear   (t_clear),
    .ack_n         (bus_ack_n),
    .data_out      (bus_data_out),
    .data_oe       (bus_data_oe),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_rdata (mem_rsp_rdata)
  );

endmodule

// File: tb/bus_ack_slave_tb.sv
module bus_ack_slave_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_as_n = 1'b1, bus_ds_n = 1'b1, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_data_in = '0;
  logic [DW-1:0] bus_data_out;
  logic          bus_data_oe, bus_ack_n;
  logic [1:0]    cfg_ack_mode = 2'd3;
  logic [CW-1:0] cfg_early_dly = '0, cfg_wr_setup = '0;
  logic          mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  always #10 clk = ~clk;

  bus_ack_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_data_in(bus_data_in),
    .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe), .bus_ack_n(bus_ack_n),
    .cfg_ack_mode(cfg_ack_mode), .cfg_early_dly(cfg_early_dly),
    .cfg_wr_setup(cfg_wr_setup), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int errs = 0;
  int checks = 0;
  logic [DW-1:0] mem [16];
  int rdy_lat = 0, rsp_lat = 0;
  bit saw_ack, saw_req, saw_oe;
  int hs_cnt = 0;
  logic [AW-1:0] last_addr;
  logic last_we;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, decisions at the falling clock edge
  initial begin
    bit hs_pend = 0;
    logic [AW-1:0] pa = '0;
    logic pwe = 0;
    logic [DW-1:0] pd = '0;
    int stall = 0;
    int rcnt = -1;
    logic [3:0] raddr = '0;
    for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0F1D + 16'h0203);
    forever begin
      @(negedge clk);
      if (!bus_ack_n) saw_ack = 1;
      if (mem_req_valid) saw_req = 1;
      if (bus_data_oe) saw_oe = 1;
      mem_rsp_valid = 1'b0;
      if (rcnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_rdata = mem[raddr];
        rcnt = -1;
      end else if (rcnt > 0) rcnt--;
      if (hs_pend) begin
        hs_cnt++;
        last_addr = pa;
        last_we = pwe;
        if (pwe) mem[pa[3:0]] = pd;
        else begin raddr = pa[3:0]; rcnt = rsp_lat; end
      end
      hs_pend = 0;
      mem_req_ready = 1'b0;
      if (mem_req_valid) begin
        if (stall >= rdy_lat) begin
          mem_req_ready = 1'b1;
          hs_pend = 1;
          pa = mem_req_addr; pwe = mem_req_we; pd = mem_req_wdata;
          stall = 0;
        end else stall++;
      end
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_cycle(
    input logic rd, input logic [AW-1:0] a, input logic [DW-1:0] wd,
    input int ds_wait, input int chg_at, input int hold,
    output int as_ack, output int ds_ack, output logic [DW-1:0] d_ack,
    output logic oe_ack, output logic rv_ack, output logic [DW-1:0] d_end,
    output logic oe_end, output int rel, output logic oe_rel);
    int e2;
    as_ack = -1; ds_ack = -1; d_ack = '0; oe_ack = 0; rv_ack = 0; rel = -1; oe_rel = 1;
    saw_ack = 0; saw_req = 0; saw_oe = 0;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_as_n = 1'b0;
    for (int e = 1; e <= ds_wait; e++) begin
      step();
      if (as_ack < 0 && !bus_ack_n) as_ack = e;
    end
    bus_data_in = wd; bus_ds_n = 1'b0;
    bus_addr = ~a; bus_rd = ~rd;
    e2 = 0;
    while (bus_ack_n && e2 < 80) begin
      step(); e2++;
      if (e2 == chg_at) bus_data_in = ~wd;
      if (!bus_ack_n) begin
        ds_ack = e2; d_ack = bus_data_out; oe_ack = bus_data_oe; rv_ack = mem_req_valid;
      end
    end
    if (!bus_ack_n) begin
      for (int h = 0; h < hold; h++) begin
        step(); e2++;
        if (e2 == chg_at) bus_data_in = ~wd;
      end
    end
    d_end = bus_data_out; oe_end = bus_data_oe;
    bus_ds_n = 1'b1; bus_as_n = 1'b1;
    for (int r = 1; r <= 10; r++) begin
      step();
      if (rel < 0 && bus_ack_n) begin rel = r; oe_rel = bus_data_oe; end
    end
    repeat (30) step();
  endtask

  initial begin
    int as_ack, ds_ack, rel, h0;
    logic [DW-1:0] d_ack, d_end, expd;
    logic oe_ack, rv_ack, oe_end, oe_rel;
    logic [AW-1:0] a;
    logic [DW-1:0] wd;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(bus_ack_n == 1'b1, "R11 ack", int'(bus_ack_n), 1);
    chk(bus_data_oe == 1'b0, "R11 oe", int'(bus_data_oe), 0);
    chk(mem_req_valid == 1'b0, "R11 req", int'(mem_req_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int m = 0; m < 4; m++) begin
      for (int rdi = 0; rdi < 2; rdi++) begin
        for (int d = 0; d < 4; d++) begin
          cfg_ack_mode  = 2'(m);
          cfg_early_dly = CW'(d);
          cfg_wr_setup  = CW'(d % 3);
          rdy_lat = d % 3;
          rsp_lat = (m == 2) ? 6 : d + 1;
          a  = {4'hA, 4'(m * 4 + d)};
          wd = 16'(16'hC35A ^ (m * 16'h0111) ^ (d * 16'h1009) ^ rdi);
          expd = mem[a[3:0]];
          h0 = hs_cnt;
          bus_cycle(rdi[0], a, wd, (m == 1) ? d + 8 : 3 + d, 4 + (d % 3),
                    (m == 1 || m == 2) ? 16 : 2,
                    as_ack, ds_ack, d_ack, oe_ack, rv_ack, d_end, oe_end, rel, oe_rel);
          if (m == 1) chk(as_ack == 4 + d, "R5 pre-strobe ack edge", as_ack, 4 + d);
          if (m == 2) chk(ds_ack == 4 + d, "R6 post-strobe ack edge", ds_ack, 4 + d);
          if ((m == 0 || m == 3) && rdi == 1) begin
            chk(oe_ack && d_ack == expd, "R7 read data at ack", int'(d_ack), int'(expd));
          end
          if ((m == 0 || m == 3) && rdi == 0)
            chk(rv_ack == 1'b0, "R7 write accepted before ack", int'(rv_ack), 0);
          chk(rel == 3, "R8 ack release edge", rel, 3);
          chk(oe_rel == 1'b0, "R8 bus released", int'(oe_rel), 0);
          chk(hs_cnt == h0 + 1, "R10 one request per cycle", hs_cnt - h0, 1);
          chk(last_addr == a && last_we == !rdi[0], "R1 latched address/direction",
              int'({last_we, last_addr}), int'({!rdi[0], a}));
          if (rdi == 1) begin
            if (m == 1 || m == 2)
              chk(oe_end && d_end == expd, "R9 late read data held", int'(d_end), int'(expd));
            else
              chk(oe_end && d_end == expd, "R4 read data on bus", int'(d_end), int'(expd));
          end else begin
            chk(mem[a[3:0]] == wd, "R3 write stored", int'(mem[a[3:0]]), int'(wd));
          end
        end
      end
    end

    // R3 sampling edge: change one edge before capture -> complement stored
    cfg_ack_mode = 2'd3;
    for (int s = 0; s < 4; s++) begin
      cfg_wr_setup = CW'(s);
      rdy_lat = 1;
      a  = {4'hA, 4'(12 + s)};
      wd = 16'(16'h5A00 + s * 16'h0107);
      bus_cycle(1'b0, a, wd, 3, 3 + s, 2,
                as_ack, ds_ack, d_ack, oe_ack, rv_ack, d_end, oe_end, rel, oe_rel);
      chk(mem[a[3:0]] == ~wd, "R3 change before sample edge", int'(mem[a[3:0]]), int'(~wd));
      bus_cycle(1'b0, a, wd, 3, 4 + s, 2,
                as_ack, ds_ack, d_ack, oe_ack, rv_ack, d_end, oe_end, rel, oe_rel);
      chk(mem[a[3:0]] == wd, "R3 change after sample edge", int'(mem[a[3:0]]), int'(wd));
    end

    // R2 unselected cycles, all modes
    for (int u = 0; u < 8; u++) begin
      cfg_ack_mode = 2'(u % 4);
      cfg_early_dly = 0;
      a = (u < 4) ? 8'(u * 16'h35) : 8'(16'hB0 + u);
      h0 = hs_cnt;
      bus_cycle(u[0], a, 16'h1234, 4, -1, 2,
                as_ack, ds_ack, d_ack, oe_ack, rv_ack, d_end, oe_end, rel, oe_rel);
      chk(!saw_ack && !saw_req && !saw_oe && hs_cnt == h0, "R2 unselected quiet",
          int'({saw_ack, saw_req, saw_oe}), 0);
    end

    summary();
    $finish;
  end
endmodule